// File: doc/BRIEF.md
# Watchdog Timer and Interrupt-Enable Control

This block holds an 8-bit control word that the CPU reads and writes over a simple register bus. The word sets up a watchdog and also carries the global interrupt-enable flag. The watchdog counts a free-running tick. That tick first passes through a programmable prescaler and then drives an 8-bit counter. When the counter overflows, the watchdog either raises a sticky interrupt request or fires a short internal reset pulse. One bit of the control word selects which of the two happens.

The interrupt-enable flag lives in the same word. Instruction strobes update it: enable, return-from-interrupt and disable. Acceptance of a hardware interrupt also clears it. The interrupt output is the pending watchdog flag gated by this enable. Software keeps the watchdog alive with a clear strobe. The three low bits of the word are stored for a neighbouring prescaler and have no effect here.

Top module: `wdt_irq_ctrl`

## Requirements
- R1: A bus write stores all 8 data bits in the control word. `rd_data_o` always shows the current word. The layout, from bit 7 down, is:
  - bit 7: timeout action
  - bit 6: interrupt enable
  - bits 5:4: prescale select
  - bit 3: watchdog enable
  - bits 2:0: stored only
- R2: Prescale select 00, 01, 10 and 11 divides the tick by 4, 16, 64 and 256. The first timeout occurs after 256×ratio enabled ticks, counted from a cleared state.
- R3: While bit 3 is 0, ticks do not advance the prescaler or the counter.
- R4: A clear strobe sets the prescaler and the counter to zero. A write that changes bits 5:4 zeroes the prescaler but leaves the counter unchanged.
- R5: In interrupt mode (bit 7 = 0), a timeout sets a sticky pending flag. `wdt_irq_o` equals pending AND bit 6. An acknowledge strobe clears the pending flag.
- R6: In reset mode (bit 7 = 1), a timeout drives `wdt_rst_o` high for exactly 4 cycles, starting the cycle after the timeout. From the first pulse cycle the word reads 0x00, and bus writes made during the pulse are ignored.
- R7: The enable and return strobes set bit 6 and the disable strobe clears it. When disable and a set strobe arrive together, bit 6 is cleared. Each strobe overrides the bit-6 value of a write in the same cycle.
- R8: Interrupt acceptance clears bit 6. This takes priority over the set strobes and over a bus write in the same cycle.
- R9: After reset, the word is 0x00 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Free-running watchdog tick enable |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 8 | Control word write data |
| rd_data_o | output | 8 | Control word read data |
| ien_set_i | input | 1 | Enable-interrupt instruction strobe |
| ret_set_i | input | 1 | Return-from-interrupt strobe |
| ien_clr_i | input | 1 | Disable-interrupt instruction strobe |
| irq_accept_i | input | 1 | Hardware interrupt accepted |
| wdt_clr_i | input | 1 | Clear-watchdog strobe |
| irq_ack_i | input | 1 | Acknowledge of watchdog interrupt |
| wdt_irq_o | output | 1 | Gated watchdog interrupt request |
| wdt_rst_o | output | 1 | Internal reset pulse |

## Verification
The assertions assume that every strobe is a single-cycle pulse. They also assume that an acknowledge never coincides with a timeout, since in that case the set wins and the assertion on clearing does not apply. The stimulus changes inputs only on the falling edge and holds the tick low whenever it writes the word or issues a clear. This keeps each timing measurement aligned to a known prescaler phase. Acknowledges are issued only after a measured timeout, while the tick is stopped.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned PRE_W = 8;

  typedef struct packed {
    logic       act;   // 0: interrupt on timeout, 1: reset
    logic       ie;
    logic [1:0] ps;
    logic       en;
    logic [2:0] aux;   // stored only
  } ctrl_t;

  function automatic logic [PRE_W-1:0] wdt_term(input logic [1:0] ps);
    case (ps)
      2'b00:   wdt_term = PRE_W'(3);
      2'b01:   wdt_term = PRE_W'(15);
      2'b10:   wdt_term = PRE_W'(63);
      default: wdt_term = PRE_W'(255);
    endcase
  endfunction
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clear_i,
  input  logic  wr_en_i,
  input  ctrl_t wr_data_i,
  input  logic  ien_set_i,
  input  logic  ret_set_i,
  input  logic  ien_clr_i,
  input  logic  accept_i,
  output ctrl_t ctrl_o
);
  ctrl_t q;

  // later assignments win: write < set < disable < accept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else if (clear_i) q <= '0;
    else begin
      if (wr_en_i) q <= wr_data_i;
      if (ien_set_i || ret_set_i) q.ie <= 1'b1;
      if (ien_clr_i) q.ie <= 1'b0;
      if (accept_i) q.ie <= 1'b0;
    end
  end

  assign ctrl_o = q;

  a_r8_accept_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> !ctrl_o.ie);
  a_r7_set_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ien_set_i || ret_set_i) && !ien_clr_i && !accept_i && !clear_i) |=> ctrl_o.ie);
  a_r7_clr_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_clr_i |=> !ctrl_o.ie);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic       clr_i,
  input  logic       pre_clr_i,
  input  logic [1:0] ps_i,
  output logic       timeout_o
);
  logic [PRE_W-1:0] pre_q, term;
  logic [CNT_W-1:0] cnt_q;
  logic adv, pre_wrap;

  assign term      = wdt_term(ps_i);
  assign adv       = tick_i && en_i;
  assign pre_wrap  = adv && (pre_q == term);
  assign timeout_o = pre_wrap && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (pre_clr_i) pre_q <= '0;
      else if (adv) pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
      if (pre_wrap) cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r2_pre_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= wdt_term(ps_i));
  a_r3_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_q));
  a_r4_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0) && (pre_q == '0));
endmodule

// File: rtl/wdt_event.sv
module wdt_event #(
  parameter int unsigned RST_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic timeout_i,
  input  logic act_i,
  input  logic ack_i,
  output logic pend_o,
  output logic start_o,
  output logic busy_o
);
  localparam int unsigned RW = $clog2(RST_LEN + 1);
  logic [RW-1:0] rcnt_q;
  logic pend_q;

  assign start_o = timeout_i && act_i;
  assign busy_o  = (rcnt_q != '0);
  assign pend_o  = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      rcnt_q <= '0;
    end else begin
      if (start_o) pend_q <= 1'b0;
      else if (timeout_i) pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;
      if (start_o) rcnt_q <= RW'(RST_LEN);
      else if (busy_o) rcnt_q <= rcnt_q - 1'b1;
    end
  end

  a_r5_pend_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_i && !act_i) |=> pend_o);
  a_r5_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !timeout_i) |=> !pend_o);
  a_r6_pulse_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> busy_o);
  a_r6_no_timeout_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !timeout_i);
endmodule

// File: rtl/wdt_irq_ctrl.sv
module wdt_irq_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_LEN = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic       ien_set_i,
  input  logic       ret_set_i,
  input  logic       ien_clr_i,
  input  logic       irq_accept_i,
  input  logic       wdt_clr_i,
  input  logic       irq_ack_i,
  output logic       wdt_irq_o,
  output logic       wdt_rst_o
);
  ctrl_t ctrl, wdata;
  logic timeout, pend, start, busy, hold, ps_chg;

  assign wdata  = ctrl_t'(wr_data_i);
  assign hold   = start || busy;
  assign ps_chg = wr_en_i && (wdata.ps != ctrl.ps);

  wdt_ctrl_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (hold),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wdata),
    .ien_set_i (ien_set_i),
    .ret_set_i (ret_set_i),
    .ien_clr_i (ien_clr_i),
    .accept_i  (irq_accept_i),
    .ctrl_o    (ctrl)
  );

  wdt_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .en_i      (ctrl.en),
    .clr_i     (wdt_clr_i || hold),
    .pre_clr_i (ps_chg),
    .ps_i      (ctrl.ps),
    .timeout_o (timeout)
  );

  wdt_event #(.RST_LEN(RST_LEN)) u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .timeout_i (timeout),
    .act_i     (ctrl.act),
    .ack_i     (irq_ack_i),
    .pend_o    (pend),
    .start_o   (start),
    .busy_o    (busy)
  );

  assign rd_data_o = ctrl;
  assign wdt_irq_o = pend && ctrl.ie;
  assign wdt_rst_o = busy;

  a_r6_word_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> (rd_data_o == 8'h00));
  a_r6_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_rst_o && wr_en_i) |=> (rd_data_o == 8'h00));
endmodule

// File: tb/tb_wdt_irq_ctrl.sv
`timescale 1ns/1ps
module tb_wdt_irq_ctrl;
  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic ien_set_i = 0, ret_set_i = 0, ien_clr_i = 0, irq_accept_i = 0;
  logic wdt_clr_i = 0, irq_ack_i = 0;
  logic wdt_irq_o, wdt_rst_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  wdt_irq_ctrl dut (.*);

  localparam int NV = 6;
  localparam logic [7:0] WVEC [NV] = '{8'h5A, 8'hA5, 8'hFF, 8'h37, 8'h6C, 8'h00};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic clr();
    wdt_clr_i = 1'b1;
    @(negedge clk_i);
    wdt_clr_i = 1'b0;
  endtask

  task automatic ack();
    irq_ack_i = 1'b1;
    @(negedge clk_i);
    irq_ack_i = 1'b0;
  endtask

  // count ticks until irq or reset output rises
  task automatic run(output int n);
    n = 0;
    tick_i = 1'b1;
    while (!(wdt_irq_o || wdt_rst_o) && n < 70000) begin
      @(posedge clk_i); n++;
      @(negedge clk_i);
    end
    tick_i = 1'b0;
  endtask

  task automatic strobe(input logic s, r, c, a);
    ien_set_i = s; ret_set_i = r; ien_clr_i = c; irq_accept_i = a;
    @(negedge clk_i);
    ien_set_i = 0; ret_set_i = 0; ien_clr_i = 0; irq_accept_i = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    chk("R9 word", rd_data_o, 8'h00);
    chk("R9 irq", wdt_irq_o, 0);
    chk("R9 rst", wdt_rst_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      wr(WVEC[i]);
      chk("R1 readback", rd_data_o, WVEC[i]);
    end

    // R7 instruction strobes
    strobe(1, 0, 0, 0); chk("R7 enable", rd_data_o[6], 1);
    strobe(0, 0, 1, 0); chk("R7 disable", rd_data_o[6], 0);
    strobe(0, 1, 0, 0); chk("R7 return", rd_data_o[6], 1);
    strobe(1, 0, 1, 0); chk("R7 disable wins", rd_data_o[6], 0);
    ien_set_i = 1; wr(8'h00); ien_set_i = 0;
    chk("R7 strobe over write", rd_data_o, 8'h40);
    // R8 acceptance priority
    strobe(1, 0, 0, 1); chk("R8 over enable", rd_data_o[6], 0);
    strobe(0, 1, 0, 1); chk("R8 over return", rd_data_o[6], 0);
    irq_accept_i = 1; wr(8'h55); irq_accept_i = 0;
    chk("R8 over write", rd_data_o, 8'h15);

    // R2 ratios, interrupt mode with enable set
    for (int p = 0; p < 4; p++) begin
      wr(8'h48 | 8'(p << 4));
      clr();
      run(n);
      chk($sformatf("R2 ratio sel %0d", p), n, 256 << (2 * (p + 1)));
      chk("R5 irq raised", wdt_irq_o, 1);
      ack();
      chk("R5 ack clears", wdt_irq_o, 0);
    end

    // R5 gating and stickiness
    wr(8'h48); clr(); run(n);
    strobe(0, 0, 1, 0); chk("R5 gated off", wdt_irq_o, 0);
    strobe(1, 0, 0, 0); chk("R5 sticky", wdt_irq_o, 1);
    ack(); chk("R5 ack", wdt_irq_o, 0);

    // R3 disabled holds count
    wr(8'h40); clr();
    tick_i = 1'b1; repeat (2000) @(negedge clk_i); tick_i = 1'b0;
    chk("R3 no timeout off", wdt_irq_o, 0);
    wr(8'h48); run(n);
    chk("R3 nothing counted", n, 1024);
    ack();

    // R4 clear strobe
    wr(8'h48); clr();
    tick_i = 1'b1; repeat (500) @(negedge clk_i); tick_i = 1'b0;
    clr(); run(n);
    chk("R4 clear restarts", n, 1024);
    ack();
    // R4 ratio change zeroes prescaler only
    wr(8'h48); clr();
    tick_i = 1'b1; repeat (2) @(negedge clk_i); tick_i = 1'b0;
    wr(8'h58); run(n);
    chk("R4 prescaler cleared", n, 4096);
    ack();

    // R6 reset mode
    wr(8'hC8); clr(); run(n);
    chk("R6 timeout ticks", n, 1024);
    chk("R6 pulse high", wdt_rst_o, 1);
    chk("R6 word cleared", rd_data_o, 8'h00);
    wr_en_i = 1'b1; wr_data_i = 8'hFF;
    n = 1;
    while (wdt_rst_o && n < 20) begin
      @(negedge clk_i);
      wr_en_i = 1'b0;
      if (wdt_rst_o) n++;
    end
    chk("R6 pulse length", n, 4);
    chk("R6 write ignored", rd_data_o, 8'h00);
    chk("R6 no irq", wdt_irq_o, 0);
    tick_i = 1'b1; repeat (1100) @(negedge clk_i); tick_i = 1'b0;
    chk("R6 stays disabled", wdt_rst_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule